// File: doc/BRIEF.md
# Internal Data Address Unit

This unit sits between the decode stage of an 8-bit microcontroller core and its internal data storage. Each cycle the core presents an operation (register access, direct access, indirect access, single or paired stack push or pop, or a bit set, clear, complement or test-and-clear). It also presents a register index, an operand address and the two bank-select bits of the status word. The unit turns these into a byte address, a space-select flag (0 for data RAM, 1 for the special-function space) and a bit index. It drives the read and write strobes that go with them.

The unit owns the stack pointer. Bit changes are done as a two-cycle read-modify-write. Paired stack operations move a 16-bit return address in two consecutive cycles. The storage arrays themselves are outside the block. The unit expects read data one cycle after a read strobe, as a synchronous RAM provides.

Control is a four-state machine:
- IDLE decodes a new operation each cycle.
- A bit operation moves IDLE to MODIFY, which returns to IDLE after one cycle.
- A paired push moves IDLE to PUSH_HI, which returns to IDLE.
- A paired pop moves IDLE to POP_LO, which returns to IDLE.
- Any other operation, and no operation, keeps the machine in IDLE.

Operation codes:

| Code | Operation |
|------|-----------|
| 0 | none |
| 1 | register |
| 2 | direct |
| 3 | indirect |
| 4 | push |
| 5 | pop |
| 6 | paired push |
| 7 | paired pop |
| 8 | bit set |
| 9 | bit clear |
| 10 | bit complement |
| 11 | bit test-and-clear |

Codes 12 to 15 act as no operation.

Top module: `iram_addr_unit`

## Requirements
- R1: A register operation (code 1) addresses byte {bank_sel[1:0], reg_idx[2:0]}, giving the four banks at 00-07, 08-0F, 10-17 and 18-1F. It selects the RAM space (mem_sfr=0) and completes in one cycle, reading when op_wr=0 and writing wr_byte when op_wr=1.
- R2: A direct operation (code 2) addresses byte opnd. It selects the special-function space exactly when opnd[7]=1.
- R3: An indirect operation (code 3) addresses byte opnd in RAM (mem_sfr=0) for every value of opnd, including 80-FF.
- R4: For a bit operation, operand values below 80h select byte 20h+opnd[6:3] in RAM. Values of 80h and above select byte {opnd[7:3],000} in the special-function space. In both cases bit_idx=opnd[2:0].
- R5: A push (code 4) writes wr_byte to RAM address SP+1 in the same cycle, and SP becomes SP+1 after the clock edge.
- R6: A pop (code 5) reads RAM address SP, and SP becomes SP-1 after the clock edge.
- R7: SP is 07h after reset and wraps modulo 256 in both directions.
- R8: Bit set, clear and complement (codes 8, 9, 10) read the byte in the first cycle. In the second cycle busy=1, the same address is written, and only the selected bit of the byte differs from the value read.
- R9: Bit test-and-clear (code 11) reports the old bit value on bit_result, with bit_result_vld=1, in its second cycle. It writes the byte back with that bit cleared only when the bit was 1; otherwise mem_wr stays 0.
- R10: A paired push (code 6) writes ret_addr[7:0] at SP+1 and then ret_addr[15:8] at SP+2. A paired pop (code 7) reads SP and then SP-1. SP moves by two in each case.
- R11: op_valid is ignored while busy=1: the latched address stays on mem_addr and SP does not change.
- R12: With op_valid=0, or with no operation selected, neither mem_rd nor mem_wr is asserted and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see table above) |
| op_wr | input | 1 | Byte operations: 1 write, 0 read |
| reg_idx | input | 3 | Working register index |
| opnd | input | 8 | Direct, indirect or bit operand address |
| bank_sel | input | 2 | Register bank select from the status word |
| wr_byte | input | 8 | Write data for byte writes and single pushes |
| ret_addr | input | 16 | Return address for a paired push |
| rd_data | input | 8 | Read data, valid one cycle after mem_rd |
| mem_addr | output | 8 | Byte address |
| mem_sfr | output | 1 | 1 selects the special-function space, 0 selects RAM |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| bit_idx | output | 3 | Bit index within the addressed byte |
| bit_result | output | 1 | Old value of the selected bit |
| bit_result_vld | output | 1 | bit_result valid (second cycle of a bit operation) |
| busy | output | 1 | Second cycle of a two-cycle operation |
| sp_out | output | 8 | Current stack pointer |

## Verification
The assertions assume that rd_data carries the byte addressed in the previous cycle whenever a read strobe was given, as a synchronous RAM returns it. They also assume that rst_n is held low for at least one clock edge before use. The bench meets both assumptions with a memory model that registers its read port and clears itself during reset. The bench changes inputs only at falling edges, and it only raises op_valid during a busy cycle in the one test that checks that such a request is dropped.

// File: rtl/iau_pkg.sv
package iau_pkg;

    typedef enum logic [3:0] {
        OPC_NOP   = 4'd0,
        OPC_REG   = 4'd1,
        OPC_DIR   = 4'd2,
        OPC_IND   = 4'd3,
        OPC_PUSH  = 4'd4,
        OPC_POP   = 4'd5,
        OPC_PUSH2 = 4'd6,
        OPC_POP2  = 4'd7,
        OPC_BSET  = 4'd8,
        OPC_BCLR  = 4'd9,
        OPC_BCPL  = 4'd10,
        OPC_BTCLR = 4'd11
    } iau_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MODIFY,
        ST_PUSH_HI,
        ST_POP_LO
    } iau_state_e;

    // Order matches op_code[1:0] of the bit operations.
    typedef enum logic [1:0] {
        BK_SET  = 2'd0,
        BK_CLR  = 2'd1,
        BK_CPL  = 2'd2,
        BK_TCLR = 2'd3
    } bit_kind_e;

endpackage

// File: rtl/iau_bit_decode.sv
module iau_bit_decode #(
    parameter int AW = 8,
    parameter logic [AW-1:0] BIT_AREA_BASE = 'h20
) (
    input  logic [AW-1:0]         bit_addr,
    output logic [AW-1:0]         byte_addr,
    output logic                  in_sfr,
    output logic [$clog2(AW)-1:0] bit_sel
);
    localparam int IW = $clog2(AW);
    localparam int RW = AW - 1 - IW;

    logic [AW-1:0] ram_byte;
    logic [AW-1:0] sfr_byte;

    // Lower half: byte offset into the bit-addressable RAM window.
    assign ram_byte  = BIT_AREA_BASE + {{(IW + 1){1'b0}}, bit_addr[AW-2:IW]};
    // Upper half: only registers on an 8-byte boundary are bit addressable.
    assign sfr_byte  = {bit_addr[AW-1:IW], {IW{1'b0}}};
    assign in_sfr    = bit_addr[AW-1];
    assign byte_addr = in_sfr ? sfr_byte : ram_byte;
    assign bit_sel   = bit_addr[IW-1:0];

    initial begin
        if (RW < 1) $error("iau_bit_decode: address width too small");
    end
endmodule

// File: rtl/iau_bit_modify.sv
module iau_bit_modify
    import iau_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0]         old_byte,
    input  logic [$clog2(DW)-1:0] sel,
    input  bit_kind_e             kind,
    output logic [DW-1:0]         new_byte,
    output logic                  old_bit,
    output logic                  need_write
);
    always_comb begin
        new_byte = old_byte;
        old_bit  = old_byte[sel];
        unique case (kind)
            BK_SET:          new_byte[sel] = 1'b1;
            BK_CLR, BK_TCLR: new_byte[sel] = 1'b0;
            BK_CPL:          new_byte[sel] = ~old_byte[sel];
        endcase
        // Test-and-clear only writes back when the bit was set.
        need_write = (kind != BK_TCLR) || old_bit;
    end
endmodule

// File: rtl/iau_stack_ptr.sv
module iau_stack_ptr #(
    parameter int AW = 8,
    parameter logic [AW-1:0] RESET_SP = 'h07
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] sp_up
);
    assign sp_up = sp + AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= RESET_SP;
        else if (inc) sp <= sp_up;
        else if (dec) sp <= sp - AW'(1);
    end

    a_r5_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> sp == $past(sp) + AW'(1));

    a_r6_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |=> sp == $past(sp) - AW'(1));

    a_r7_reset_sp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sp == RESET_SP);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !dec) |=> $stable(sp));
endmodule

// File: rtl/iram_addr_unit.sv
module iram_addr_unit
    import iau_pkg::*;
#(
    parameter int AW = 8,
    parameter int RIDX_W = 3,
    parameter int BANK_W = 2,
    parameter logic [AW-1:0] BIT_AREA_BASE = 'h20,
    parameter logic [AW-1:0] RESET_SP = 'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic              op_wr,
    input  logic [RIDX_W-1:0] reg_idx,
    input  logic [AW-1:0]     opnd,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [AW-1:0]     wr_byte,
    input  logic [2*AW-1:0]   ret_addr,
    input  logic [AW-1:0]     rd_data,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_sfr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [AW-1:0]     mem_wdata,
    output logic [$clog2(AW)-1:0] bit_idx,
    output logic              bit_result,
    output logic              bit_result_vld,
    output logic              busy,
    output logic [AW-1:0]     sp_out
);
    localparam int IW  = $clog2(AW);
    localparam int RFW = RIDX_W + BANK_W;

    iau_op_e    op;
    iau_state_e state_q, state_d;
    logic       is_bit_op;
    bit_kind_e  new_kind;

    logic [AW-1:0] sp, sp_up;
    logic          sp_inc, sp_dec;
    logic [AW-1:0] dec_addr;
    logic          dec_sfr;
    logic [IW-1:0] dec_idx;
    logic [AW-1:0] mod_byte;
    logic          mod_old, mod_wr;

    logic [AW-1:0] lat_addr;
    logic          lat_sfr;
    logic [IW-1:0] lat_idx;
    bit_kind_e     lat_kind;
    logic [AW-1:0] hi_q;

    assign op        = iau_op_e'(op_code);
    assign is_bit_op = (op_code[3:2] == 2'b10);
    assign new_kind  = bit_kind_e'(op_code[1:0]);
    assign sp_out    = sp;

    iau_stack_ptr #(.AW(AW), .RESET_SP(RESET_SP)) stack_i (
        .clk(clk), .rst_n(rst_n), .inc(sp_inc), .dec(sp_dec),
        .sp(sp), .sp_up(sp_up)
    );

    iau_bit_decode #(.AW(AW), .BIT_AREA_BASE(BIT_AREA_BASE)) bdec_i (
        .bit_addr(opnd), .byte_addr(dec_addr), .in_sfr(dec_sfr), .bit_sel(dec_idx)
    );

    iau_bit_modify #(.DW(AW)) bmod_i (
        .old_byte(rd_data), .sel(lat_idx), .kind(lat_kind),
        .new_byte(mod_byte), .old_bit(mod_old), .need_write(mod_wr)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Operation latches for the second cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_sfr  <= 1'b0;
            lat_idx  <= '0;
            lat_kind <= BK_SET;
            hi_q     <= '0;
        end else if (state_q == ST_IDLE && op_valid) begin
            if (is_bit_op) begin
                lat_addr <= dec_addr;
                lat_sfr  <= dec_sfr;
                lat_idx  <= dec_idx;
                lat_kind <= new_kind;
            end
            if (op == OPC_PUSH2) hi_q <= ret_addr[2*AW-1:AW];
        end
    end

    // Next state and outputs
    always_comb begin
        state_d        = state_q;
        mem_addr       = '0;
        mem_sfr        = 1'b0;
        mem_rd         = 1'b0;
        mem_wr         = 1'b0;
        mem_wdata      = '0;
        bit_idx        = '0;
        bit_result     = 1'b0;
        bit_result_vld = 1'b0;
        busy           = 1'b0;
        sp_inc         = 1'b0;
        sp_dec         = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (op_valid) begin
                    case (op)
                        OPC_REG: begin
                            mem_addr  = {{(AW-RFW){1'b0}}, bank_sel, reg_idx};
                            mem_rd    = !op_wr;
                            mem_wr    = op_wr;
                            mem_wdata = wr_byte;
                        end
                        OPC_DIR: begin
                            mem_addr  = opnd;
                            mem_sfr   = opnd[AW-1];
                            mem_rd    = !op_wr;
                            mem_wr    = op_wr;
                            mem_wdata = wr_byte;
                        end
                        OPC_IND: begin
                            mem_addr  = opnd;
                            mem_rd    = !op_wr;
                            mem_wr    = op_wr;
                            mem_wdata = wr_byte;
                        end
                        OPC_PUSH: begin
                            mem_addr  = sp_up;
                            mem_wr    = 1'b1;
                            mem_wdata = wr_byte;
                            sp_inc    = 1'b1;
                        end
                        OPC_POP: begin
                            mem_addr = sp;
                            mem_rd   = 1'b1;
                            sp_dec   = 1'b1;
                        end
                        OPC_PUSH2: begin
                            mem_addr  = sp_up;
                            mem_wr    = 1'b1;
                            mem_wdata = ret_addr[AW-1:0];
                            sp_inc    = 1'b1;
                            state_d   = ST_PUSH_HI;
                        end
                        OPC_POP2: begin
                            mem_addr = sp;
                            mem_rd   = 1'b1;
                            sp_dec   = 1'b1;
                            state_d  = ST_POP_LO;
                        end
                        OPC_BSET, OPC_BCLR, OPC_BCPL, OPC_BTCLR: begin
                            mem_addr = dec_addr;
                            mem_sfr  = dec_sfr;
                            bit_idx  = dec_idx;
                            mem_rd   = 1'b1;
                            state_d  = ST_MODIFY;
                        end
                        default: ;
                    endcase
                end
            end
            ST_MODIFY: begin
                mem_addr       = lat_addr;
                mem_sfr        = lat_sfr;
                bit_idx        = lat_idx;
                mem_wr         = mod_wr;
                mem_wdata      = mod_byte;
                bit_result     = mod_old;
                bit_result_vld = 1'b1;
                busy           = 1'b1;
                state_d        = ST_IDLE;
            end
            ST_PUSH_HI: begin
                mem_addr  = sp_up;
                mem_wr    = 1'b1;
                mem_wdata = hi_q;
                sp_inc    = 1'b1;
                busy      = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_POP_LO: begin
                mem_addr = sp;
                mem_rd   = 1'b1;
                sp_dec   = 1'b1;
                busy     = 1'b1;
                state_d  = ST_IDLE;
            end
        endcase
    end

    // R8: second cycle of a bit operation stays on the byte that was read
    a_r8_rmw_same_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && op_valid && is_bit_op) |=>
            (busy && mem_addr == $past(mem_addr) && mem_sfr == $past(mem_sfr)));

    // R8: write-back differs from the byte read in at most one bit
    a_r8_one_bit_changed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MODIFY && mem_wr) |-> $countones(mem_wdata ^ rd_data) <= 1);

    // R9: test-and-clear writes only a set bit, and writes it cleared
    a_r9_tclr_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MODIFY && lat_kind == BK_TCLR && mem_wr) |->
            (rd_data[lat_idx] && !mem_wdata[lat_idx]));

    // R10: second byte of a paired push goes one address above the first
    a_r10_pair_push_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && op_valid && op == OPC_PUSH2) |=>
            (mem_wr && mem_addr == $past(mem_addr) + AW'(1)));

    // R10: second read of a paired pop goes one address below the first
    a_r10_pair_pop_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && op_valid && op == OPC_POP2) |=>
            (mem_rd && mem_addr == $past(mem_addr) - AW'(1)));

    // R11: a busy cycle is always followed by a free one
    a_r11_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R12: no strobe without a request
    a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !op_valid) |-> (!mem_rd && !mem_wr && !busy));

    // R3: indirect access never reaches the special-function space
    a_r3_ind_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && op_valid && op == OPC_IND) |-> !mem_sfr);
endmodule

// File: tb/iram_addr_unit_tb_top.sv
`timescale 1ns/100ps
module iram_addr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        op_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [7:0]  opnd = '0;
    logic [1:0]  bank_sel = '0;
    logic [7:0]  wr_byte = '0;
    logic [15:0] ret_addr = '0;
    logic [7:0]  rd_data;
    logic [7:0]  mem_addr, mem_wdata, sp_out;
    logic        mem_sfr, mem_rd, mem_wr, bit_result, bit_result_vld, busy;
    logic [2:0]  bit_idx;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    iram_addr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_wr(op_wr), .reg_idx(reg_idx), .opnd(opnd), .bank_sel(bank_sel),
        .wr_byte(wr_byte), .ret_addr(ret_addr), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_sfr(mem_sfr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .bit_idx(bit_idx), .bit_result(bit_result),
        .bit_result_vld(bit_result_vld), .busy(busy), .sp_out(sp_out)
    );

    // Synchronous memory model: RAM and special-function space
    logic [7:0] ram [256];
    logic [7:0] sfr [256];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                ram[i] <= 8'h00;
                sfr[i] <= 8'h00;
            end
            rd_data <= 8'h00;
        end else begin
            if (mem_wr) begin
                if (mem_sfr) sfr[mem_addr] <= mem_wdata;
                else         ram[mem_addr] <= mem_wdata;
            end
            if (mem_rd) rd_data <= mem_sfr ? sfr[mem_addr] : ram[mem_addr];
        end
    end

    // {op, idx, opnd, bank, exp_addr, exp_sfr, exp_bit}
    localparam int NV = 13;
    localparam logic [28:0] VEC [NV] = '{
        {4'd1,  3'd5, 8'h00, 2'd0, 8'h05, 1'b0, 3'd0},  // R1 bank 0
        {4'd1,  3'd7, 8'h00, 2'd3, 8'h1F, 1'b0, 3'd0},  // R1 bank 3
        {4'd1,  3'd0, 8'h00, 2'd2, 8'h10, 1'b0, 3'd0},  // R1 bank 2
        {4'd2,  3'd0, 8'h3A, 2'd0, 8'h3A, 1'b0, 3'd0},  // R2 low half
        {4'd2,  3'd0, 8'h99, 2'd0, 8'h99, 1'b1, 3'd0},  // R2 upper half -> SFR
        {4'd3,  3'd0, 8'h99, 2'd0, 8'h99, 1'b0, 3'd0},  // R3 upper RAM
        {4'd3,  3'd0, 8'h7F, 2'd0, 8'h7F, 1'b0, 3'd0},  // R3 low RAM
        {4'd8,  3'd0, 8'h00, 2'd0, 8'h20, 1'b0, 3'd0},  // R4 first bit
        {4'd9,  3'd0, 8'h7F, 2'd0, 8'h2F, 1'b0, 3'd7},  // R4 last RAM bit
        {4'd10, 3'd0, 8'h43, 2'd0, 8'h28, 1'b0, 3'd3},  // R4 middle
        {4'd8,  3'd0, 8'h80, 2'd0, 8'h80, 1'b1, 3'd0},  // R4 first SFR bit
        {4'd11, 3'd0, 8'hD5, 2'd0, 8'hD0, 1'b1, 3'd5},  // R4 SFR
        {4'd10, 3'd0, 8'hFF, 2'd0, 8'hF8, 1'b1, 3'd7}   // R4 last SFR bit
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [2:0] idx, input logic [7:0] a,
                         input logic [1:0] bk, input logic w, input logic [7:0] b,
                         input logic [15:0] ra);
        @(negedge clk);
        op_code = op; reg_idx = idx; opnd = a; bank_sel = bk;
        op_wr = w; wr_byte = b; ret_addr = ra; op_valid = 1'b1;
        #1;
    endtask

    task automatic next_cyc;
        @(negedge clk);
        op_valid = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // Reset state
        chk("R7 sp reset", sp_out, 8'h07);
        chk("R12 idle busy", busy, 1'b0);
        chk("R12 idle rd", mem_rd, 1'b0);
        chk("R12 idle wr", mem_wr, 1'b0);

        // Vector table: address decode of first cycle
        for (int v = 0; v < NV; v++) begin
            logic [28:0] e;
            e = VEC[v];
            drive(e[28:25], e[24:22], e[21:14], e[13:12], 1'b0, 8'h00, 16'h0);
            if (e[28:25] >= 4'd8) begin
                chk("R4 addr", mem_addr, e[11:4]);
                chk("R4 space", mem_sfr, e[3]);
                chk("R4 bit", bit_idx, e[2:0]);
            end else begin
                chk("R1 R2 R3 addr", mem_addr, e[11:4]);
                chk("R2 R3 space", mem_sfr, e[3]);
            end
            chk("R1 read strobe", mem_rd, 1'b1);
            next_cyc();
            if (busy) next_cyc();
        end

        // R12: no operation
        drive(4'd0, 3'd1, 8'h55, 2'd1, 1'b1, 8'hAA, 16'h0);
        chk("R12 nop rd", mem_rd, 1'b0);
        chk("R12 nop wr", mem_wr, 1'b0);
        next_cyc();
        chk("R12 nop busy", busy, 1'b0);

        // R1 write
        drive(4'd1, 3'd2, 8'h00, 2'd1, 1'b1, 8'h5A, 16'h0);
        chk("R1 write addr", mem_addr, 8'h0A);
        chk("R1 write strobe", mem_wr, 1'b1);
        chk("R1 write data", mem_wdata, 8'h5A);
        chk("R1 no read", mem_rd, 1'b0);
        next_cyc();

        // R2 presets through direct writes
        drive(4'd2, 3'd0, 8'h21, 2'd0, 1'b1, 8'h0F, 16'h0);
        chk("R2 ram write", mem_sfr, 1'b0);
        next_cyc();
        drive(4'd2, 3'd0, 8'h88, 2'd0, 1'b1, 8'h20, 16'h0);
        chk("R2 sfr write", mem_sfr, 1'b1);
        next_cyc();

        // R8: set bit 4 of byte 21
        drive(4'd8, 3'd0, 8'h0C, 2'd0, 1'b0, 8'h00, 16'h0);
        chk("R8 set addr", mem_addr, 8'h21);
        chk("R8 set read", mem_rd, 1'b1);
        chk("R8 set bit", bit_idx, 3'd4);
        next_cyc();
        chk("R8 set busy", busy, 1'b1);
        chk("R8 set wr", mem_wr, 1'b1);
        chk("R8 set same addr", mem_addr, 8'h21);
        chk("R8 set data", mem_wdata, 8'h1F);
        next_cyc();
        chk("R8 done", busy, 1'b0);
        // clear bit 0
        drive(4'd9, 3'd0, 8'h08, 2'd0, 1'b0, 8'h00, 16'h0);
        next_cyc();
        chk("R8 clr data", mem_wdata, 8'h1E);
        // complement bit 1
        drive(4'd10, 3'd0, 8'h09, 2'd0, 1'b0, 8'h00, 16'h0);
        next_cyc();
        chk("R8 cpl data", mem_wdata, 8'h1C);
        drive(4'd2, 3'd0, 8'h21, 2'd0, 1'b0, 8'h00, 16'h0);
        next_cyc();
        chk("R8 stored byte", rd_data, 8'h1C);

        // R9: test-and-clear on SFR 88 bit 5
        drive(4'd11, 3'd0, 8'h8D, 2'd0, 1'b0, 8'h00, 16'h0);
        chk("R9 addr", mem_addr, 8'h88);
        chk("R9 space", mem_sfr, 1'b1);
        next_cyc();
        chk("R9 result set", bit_result, 1'b1);
        chk("R9 result vld", bit_result_vld, 1'b1);
        chk("R9 write when set", mem_wr, 1'b1);
        chk("R9 cleared data", mem_wdata, 8'h00);
        drive(4'd11, 3'd0, 8'h8D, 2'd0, 1'b0, 8'h00, 16'h0);
        next_cyc();
        chk("R9 result clear", bit_result, 1'b0);
        chk("R9 no write when clear", mem_wr, 1'b0);
        drive(4'd2, 3'd0, 8'h88, 2'd0, 1'b0, 8'h00, 16'h0);
        next_cyc();
        chk("R9 stored byte", rd_data, 8'h00);

        // R11: request during busy cycle is dropped
        drive(4'd8, 3'd0, 8'h0F, 2'd0, 1'b0, 8'h00, 16'h0);
        @(negedge clk);
        op_code = 4'd4; wr_byte = 8'hEE; op_valid = 1'b1;
        #1;
        chk("R11 busy", busy, 1'b1);
        chk("R11 latched addr", mem_addr, 8'h21);
        chk("R8 set bit 7", mem_wdata, 8'h9C);
        next_cyc();
        chk("R11 sp unchanged", sp_out, 8'h07);

        // R5 / R6: single push and pop
        drive(4'd4, 3'd0, 8'h00, 2'd0, 1'b0, 8'hA5, 16'h0);
        chk("R5 push addr", mem_addr, 8'h08);
        chk("R5 push wr", mem_wr, 1'b1);
        chk("R5 push space", mem_sfr, 1'b0);
        chk("R5 push data", mem_wdata, 8'hA5);
        next_cyc();
        chk("R5 sp after push", sp_out, 8'h08);
        drive(4'd5, 3'd0, 8'h00, 2'd0, 1'b0, 8'h00, 16'h0);
        chk("R6 pop addr", mem_addr, 8'h08);
        chk("R6 pop rd", mem_rd, 1'b1);
        next_cyc();
        chk("R6 sp after pop", sp_out, 8'h07);
        chk("R6 pop data", rd_data, 8'hA5);

        // R10: paired push and pop
        drive(4'd6, 3'd0, 8'h00, 2'd0, 1'b0, 8'h00, 16'h1234);
        chk("R10 low addr", mem_addr, 8'h08);
        chk("R10 low data", mem_wdata, 8'h34);
        next_cyc();
        chk("R10 high busy", busy, 1'b1);
        chk("R10 high addr", mem_addr, 8'h09);
        chk("R10 high data", mem_wdata, 8'h12);
        chk("R10 high wr", mem_wr, 1'b1);
        next_cyc();
        chk("R10 sp after pair push", sp_out, 8'h09);
        drive(4'd7, 3'd0, 8'h00, 2'd0, 1'b0, 8'h00, 16'h0);
        chk("R10 pop first addr", mem_addr, 8'h09);
        next_cyc();
        chk("R10 pop second addr", mem_addr, 8'h08);
        chk("R10 pop high byte", rd_data, 8'h12);
        next_cyc();
        chk("R10 pop low byte", rd_data, 8'h34);
        chk("R10 sp after pair pop", sp_out, 8'h07);

        // R7: wrap below zero and above FF
        for (int k = 0; k < 8; k++) begin
            drive(4'd5, 3'd0, 8'h00, 2'd0, 1'b0, 8'h00, 16'h0);
            next_cyc();
        end
        chk("R7 wrap down", sp_out, 8'hFF);
        drive(4'd4, 3'd0, 8'h00, 2'd0, 1'b0, 8'h77, 16'h0);
        chk("R7 push addr wraps", mem_addr, 8'h00);
        next_cyc();
        chk("R7 wrap up", sp_out, 8'h00);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule